// File: doc/BRIEF.md
# Video Pixel Output Formatter

This block sits at the output of a video decoder. It takes 4:2:2 samples: one luma value per pixel, one chroma value per pixel that alternates between Cb and Cr, and a precomputed 8-bit-per-channel RGB triple. It also takes the line timing flags. From these it drives a registered 16-bit pixel bus in one of four formats: byte-multiplexed YCbCr, 16-bit YCbCr, RGB 5-5-5 or RGB 5-6-5. A sample slot is qualified by `in_vld`. A slot is "forced blank" when `in_blank` is high and `in_vbi_vld` is low. In a forced-blank slot the bus carries blanking levels instead of sample data. When VBI data is valid, the slot is formatted as ordinary data even inside blanking.

The block also produces a registered data-valid qualifier, and its behaviour is picked by three control bits. It registers the blank, horizontal sync, vertical sync, field and VBI-valid flags onto the output clock edge. One 8-bit control register, written through `cfg_wr_en`/`cfg_wr_data`, selects the format and the qualifier behaviour.

The async active-low reset is synchronised inside the block. All outputs and the control register clear during reset.

Top module: `pixout_fmt`

## Requirements
- R1: In byte mode (format code 0), successive valid slots place bytes on pix_o[15:8] in the repeating order Cb, Y, Cr, Y. Slots at phase 0 and 2 carry in_c, slots at phase 1 and 3 carry in_y. pix_o[7:0] is 0.
- R2: The first non-forced valid slot after a forced-blank slot, and the first valid slot after reset, starts at phase 0, so each line's first active byte is a Cb sample. The phase advances by one on every valid slot, whether forced or not.
- R3: A slot is forced blank only when in_blank=1 and in_vbi_vld=0. In byte mode the forced byte is 128 at even phases and 16 at odd phases. In 16-bit YCbCr mode the forced word is 0x1080.
- R4: In both RGB formats a forced-blank slot outputs 0.
- R5: In 16-bit YCbCr mode (format code 1), pix_o = {in_y, in_c}.
- R6: Format code 2 outputs {0, r[7:3], g[7:3], b[7:3]}. Format code 3 outputs {r[7:3], g[7:2], b[7:3]}.
- R7: blank_o, hsync_o, vsync_o, field_o and vbi_vld_o equal the corresponding inputs one clock earlier, every cycle.
- R8: pix_o shows a loaded slot one clock later. It holds its value across cycles with in_vld=0 and across slots that are not loaded.
- R9: With the strobe bit and half-rate bit clear, the raw qualifier is high exactly for valid slots that are not forced blank.
- R10: With the strobe bit (bit 4) set, the raw qualifier is high for every loaded slot, including forced-blank slots.
- R11: With the half-rate bit (bit 5) set in a 16-bit format, only slots at even phase load a new word and raise the qualifier. Odd-phase slots hold the word. The bit has no effect in byte mode.
- R12: dvalid_o is the raw qualifier XOR the polarity bit (bit 6), registered. With in_vld=0 it equals the polarity bit.
- R13: The control register fields are format = bits [1:0], strobe = bit 4, half-rate = bit 5, polarity = bit 6. A write takes effect from the next clock. After reset all fields are 0 and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Control register write strobe |
| cfg_wr_data | input | 8 | Control register write value |
| in_vld | input | 1 | Sample slot present |
| in_y | input | 8 | Luma sample |
| in_c | input | 8 | Chroma sample (Cb or Cr, alternating) |
| in_r | input | 8 | Red component |
| in_g | input | 8 | Green component |
| in_b | input | 8 | Blue component |
| in_blank | input | 1 | Blanking interval flag |
| in_hsync | input | 1 | Horizontal sync flag |
| in_vsync | input | 1 | Vertical sync flag |
| in_field | input | 1 | Field flag |
| in_vbi_vld | input | 1 | VBI data valid flag |
| pix_o | output | 16 | Formatted pixel bus |
| dvalid_o | output | 1 | Data-valid qualifier |
| blank_o | output | 1 | Registered blank flag |
| hsync_o | output | 1 | Registered horizontal sync |
| vsync_o | output | 1 | Registered vertical sync |
| field_o | output | 1 | Registered field flag |
| vbi_vld_o | output | 1 | Registered VBI-valid flag |

## Verification
Each control setting is driven over two lines. Every line has a forced-blank run, a stretch of blanking with VBI valid, a second forced-blank run and an active stretch with random gaps in `in_vld`.

- The forced-blank versus VBI-valid slots show whether the forcing rule looks at both flags.
- The forced-blank to active boundary shows whether the phase restarts on Cb.
- The gaps show whether the data holds and whether the qualifier follows the polarity bit alone.
- Random sample values separate the byte order and the RGB bit packing.
- Half-rate is tried in byte mode as well as in the 16-bit formats, so the test shows that byte mode ignores it.

// File: rtl/pof_pkg.sv
package pof_pkg;

  typedef enum logic [1:0] {
    FMT_YC8    = 2'd0,
    FMT_YC16   = 2'd1,
    FMT_RGB555 = 2'd2,
    FMT_RGB565 = 2'd3
  } fmt_e;

  typedef struct packed {
    logic pol_low;
    logic dv_half;
    logic dv_strobe;
    fmt_e fmt;
  } ctrl_t;

  localparam int CTRL_FMT_LSB    = 0;
  localparam int CTRL_STROBE_BIT = 4;
  localparam int CTRL_HALF_BIT   = 5;
  localparam int CTRL_POL_BIT    = 6;

  localparam int NFLAG = 5;
  localparam int FL_BLANK = 0;
  localparam int FL_HSYNC = 1;
  localparam int FL_VSYNC = 2;
  localparam int FL_FIELD = 3;
  localparam int FL_VBI   = 4;

endpackage

// File: rtl/pof_ctrl_reg.sv
module pof_ctrl_reg
  import pof_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_data,
  output ctrl_t         ctrl_o
);

  ctrl_t ctrl_q;
  ctrl_t ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) begin
      ctrl_d.fmt       = fmt_e'(wr_data[CTRL_FMT_LSB +: 2]);
      ctrl_d.dv_strobe = wr_data[CTRL_STROBE_BIT];
      ctrl_d.dv_half   = wr_data[CTRL_HALF_BIT];
      ctrl_d.pol_low   = wr_data[CTRL_POL_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;

  assert_cfg_fields_R13: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ctrl_o.fmt == fmt_e'($past(wr_data[1:0]))) &&
              (ctrl_o.pol_low == $past(wr_data[CTRL_POL_BIT])));

endmodule

// File: rtl/pof_phase.sv
module pof_phase #(
  parameter int PW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slot_vld,
  input  logic          forced,
  output logic [PW-1:0] phase_o
);

  logic [PW-1:0] phase_q, phase_d;
  logic          prevf_q, prevf_d;
  logic          restart;

  // an active slot that follows a forced-blank slot begins a new line at Cb
  assign restart = prevf_q & ~forced;
  assign phase_o = restart ? '0 : phase_q;

  always_comb begin
    phase_d = phase_q;
    prevf_d = prevf_q;
    if (slot_vld) begin
      phase_d = phase_o + 1'b1;
      prevf_d = forced;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      prevf_q <= 1'b1;
    end else begin
      phase_q <= phase_d;
      prevf_q <= prevf_d;
    end
  end

  assert_phase_steps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_vld && !(prevf_q && !forced)) |=> (phase_q == $past(phase_q) + 1'b1));

endmodule

// File: rtl/pof_fmt_mux.sv
module pof_fmt_mux
  import pof_pkg::*;
#(
  parameter int SW = 8,
  parameter int PW = 2,
  localparam int OW = 2 * SW
) (
  input  fmt_e          fmt,
  input  logic [PW-1:0] phase,
  input  logic          forced,
  input  logic [SW-1:0] y,
  input  logic [SW-1:0] c,
  input  logic [SW-1:0] r,
  input  logic [SW-1:0] g,
  input  logic [SW-1:0] b,
  output logic [OW-1:0] word_o
);

  localparam logic [SW-1:0] BLK_Y = SW'(16) << (SW - 8);
  localparam logic [SW-1:0] BLK_C = SW'(1) << (SW - 1);

  logic [OW-1:0] rgb555, rgb565;

  assign rgb555 = OW'({1'b0, r[SW-1 -: 5], g[SW-1 -: 5], b[SW-1 -: 5]});
  assign rgb565 = OW'({r[SW-1 -: 5], g[SW-1 -: 6], b[SW-1 -: 5]});

  always_comb begin
    word_o = '0;
    unique case (fmt)
      FMT_YC8: begin
        if (forced) word_o[OW-1:SW] = phase[0] ? BLK_Y : BLK_C;
        else        word_o[OW-1:SW] = phase[0] ? y : c;
      end
      FMT_YC16:   word_o = forced ? {BLK_Y, BLK_C} : {y, c};
      FMT_RGB555: word_o = forced ? '0 : rgb555;
      default:    word_o = forced ? '0 : rgb565;
    endcase
  end

endmodule

// File: rtl/pof_out_stage.sv
module pof_out_stage
  import pof_pkg::*;
#(
  parameter int OW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [OW-1:0]    word_d,
  input  logic             dv_d,
  input  logic [NFLAG-1:0] flags_d,
  output logic [OW-1:0]    word_o,
  output logic             dv_o,
  output logic [NFLAG-1:0] flags_o
);

  logic [OW-1:0] word_q, word_n;
  logic          dv_q;

  always_comb begin
    word_n = word_q;
    if (load) word_n = word_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      dv_q   <= 1'b0;
    end else begin
      word_q <= word_n;
      dv_q   <= dv_d;
    end
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    logic fl_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fl_q <= 1'b0;
      else        fl_q <= flags_d[i];
    end
    assign flags_o[i] = fl_q;
  end

  assign word_o = word_q;
  assign dv_o   = dv_q;

  assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(word_o));

endmodule

// File: rtl/pixout_fmt.sv
module pixout_fmt
  import pof_pkg::*;
#(
  parameter int SW = 8,
  parameter int CW = 8,
  localparam int OW = 2 * SW,
  localparam int PW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr_en,
  input  logic [CW-1:0] cfg_wr_data,
  input  logic          in_vld,
  input  logic [SW-1:0] in_y,
  input  logic [SW-1:0] in_c,
  input  logic [SW-1:0] in_r,
  input  logic [SW-1:0] in_g,
  input  logic [SW-1:0] in_b,
  input  logic          in_blank,
  input  logic          in_hsync,
  input  logic          in_vsync,
  input  logic          in_field,
  input  logic          in_vbi_vld,
  output logic [OW-1:0] pix_o,
  output logic          dvalid_o,
  output logic          blank_o,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          field_o,
  output logic          vbi_vld_o
);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_s1, rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_ns <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_ns <= rst_s1;
    end
  end

  ctrl_t         ctrl;
  logic [PW-1:0] phase;
  logic          forced, half_skip, load, dv_raw, dv_d;
  logic [OW-1:0] word;
  logic [NFLAG-1:0] flags_d, flags_q;

  pof_ctrl_reg #(.CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_ns), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data), .ctrl_o(ctrl)
  );

  assign forced = in_blank & ~in_vbi_vld;

  pof_phase #(.PW(PW)) u_phase (
    .clk(clk), .rst_n(rst_ns), .slot_vld(in_vld), .forced(forced), .phase_o(phase)
  );

  pof_fmt_mux #(.SW(SW), .PW(PW)) u_mux (
    .fmt(ctrl.fmt), .phase(phase), .forced(forced),
    .y(in_y), .c(in_c), .r(in_r), .g(in_g), .b(in_b), .word_o(word)
  );

  assign half_skip = ctrl.dv_half & (ctrl.fmt != FMT_YC8) & phase[0];
  assign load      = in_vld & ~half_skip;
  assign dv_raw    = ctrl.dv_strobe ? load : (load & ~forced);
  assign dv_d      = dv_raw ^ ctrl.pol_low;

  always_comb begin
    flags_d           = '0;
    flags_d[FL_BLANK] = in_blank;
    flags_d[FL_HSYNC] = in_hsync;
    flags_d[FL_VSYNC] = in_vsync;
    flags_d[FL_FIELD] = in_field;
    flags_d[FL_VBI]   = in_vbi_vld;
  end

  pof_out_stage #(.OW(OW)) u_out (
    .clk(clk), .rst_n(rst_ns), .load(load), .word_d(word), .dv_d(dv_d),
    .flags_d(flags_d), .word_o(pix_o), .dv_o(dvalid_o), .flags_o(flags_q)
  );

  assign blank_o   = flags_q[FL_BLANK];
  assign hsync_o   = flags_q[FL_HSYNC];
  assign vsync_o   = flags_q[FL_VSYNC];
  assign field_o   = flags_q[FL_FIELD];
  assign vbi_vld_o = flags_q[FL_VBI];

  // independent line-start tracker used only by the checks below
  logic chk_prevf_q;
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)     chk_prevf_q <= 1'b1;
    else if (in_vld) chk_prevf_q <= in_blank & ~in_vbi_vld;
  end

  assert_line_starts_cb_R2: assert property (@(posedge clk) disable iff (!rst_ns)
    (in_vld && chk_prevf_q && !in_blank && ctrl.fmt == FMT_YC8) |=>
      (pix_o[OW-1:SW] == $past(in_c)));

  assert_byte_low_zero_R1: assert property (@(posedge clk) disable iff (!rst_ns)
    (load && ctrl.fmt == FMT_YC8) |=> (pix_o[SW-1:0] == '0));

  assert_rgb_blank_zero_R4: assert property (@(posedge clk) disable iff (!rst_ns)
    (load && in_blank && !in_vbi_vld && ctrl.fmt[1]) |=> (pix_o == '0));

  assert_no_dv_in_blank_R9: assert property (@(posedge clk) disable iff (!rst_ns)
    (in_vld && in_blank && !in_vbi_vld && !ctrl.dv_strobe) |=>
      (dvalid_o == $past(ctrl.pol_low)));

  assert_idle_dv_pol_R12: assert property (@(posedge clk) disable iff (!rst_ns)
    !in_vld |=> (dvalid_o == $past(ctrl.pol_low)));

  assert_hsync_delay_R7: assert property (@(posedge clk) disable iff (!rst_ns)
    1'b1 |=> (hsync_o == $past(in_hsync)) && (field_o == $past(in_field)));

endmodule

// File: tb/pixout_fmt_tb.sv
module pixout_fmt_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr_en;
  logic [7:0]  cfg_wr_data;
  logic        in_vld, in_blank, in_hsync, in_vsync, in_field, in_vbi_vld;
  logic [7:0]  in_y, in_c, in_r, in_g, in_b;
  logic [15:0] pix_o;
  logic        dvalid_o, blank_o, hsync_o, vsync_o, field_o, vbi_vld_o;

  always #5 clk = ~clk;

  pixout_fmt dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .in_vld(in_vld), .in_y(in_y), .in_c(in_c), .in_r(in_r), .in_g(in_g), .in_b(in_b),
    .in_blank(in_blank), .in_hsync(in_hsync), .in_vsync(in_vsync), .in_field(in_field),
    .in_vbi_vld(in_vbi_vld), .pix_o(pix_o), .dvalid_o(dvalid_o), .blank_o(blank_o),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .field_o(field_o), .vbi_vld_o(vbi_vld_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // bench model state
  logic [1:0]  m_fmt;
  logic        m_strobe, m_half, m_pol;
  logic [1:0]  m_phase;
  logic        m_prevf;
  logic [15:0] m_pix;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] exp_word(input logic [1:0] fmt, input logic [1:0] ph,
      input logic forced, input logic [7:0] y, c, r, g, b);
    case (fmt)
      2'd0:    return forced ? {(ph[0] ? 8'd16 : 8'd128), 8'h00} : {(ph[0] ? y : c), 8'h00};
      2'd1:    return forced ? 16'h1080 : {y, c};
      2'd2:    return forced ? 16'h0000 : {1'b0, r[7:3], g[7:3], b[7:3]};
      default: return forced ? 16'h0000 : {r[7:3], g[7:2], b[7:3]};
    endcase
  endfunction

  function automatic string pix_tag(input logic [1:0] fmt, input logic forced);
    if (forced) return fmt[1] ? "R4" : "R3";
    case (fmt)
      2'd0:    return "R1";
      2'd1:    return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_data = v; in_vld = 1'b0;
    @(posedge clk); #2;
    m_fmt = v[1:0]; m_strobe = v[4]; m_half = v[5]; m_pol = v[6];
  endtask

  task automatic slot(input logic v, input logic bl, input logic vb, input logic hs,
                      input logic vs, input logic fd);
    logic [7:0] y, c, r, g, b;
    logic forced, skip, ld, raw, first8;
    logic [1:0] eff;
    logic [15:0] hold;
    string dtag;
    y = 8'($urandom); c = 8'($urandom); r = 8'($urandom); g = 8'($urandom); b = 8'($urandom);
    @(negedge clk);
    cfg_wr_en = 1'b0;
    in_vld = v; in_blank = bl; in_vbi_vld = vb; in_hsync = hs; in_vsync = vs; in_field = fd;
    in_y = y; in_c = c; in_r = r; in_g = g; in_b = b;
    forced = bl & ~vb;
    eff    = (m_prevf & ~forced) ? 2'd0 : m_phase;
    skip   = m_half && (m_fmt != 2'd0) && eff[0];
    ld     = v & ~skip;
    raw    = m_strobe ? ld : (ld & ~forced);
    first8 = v && m_prevf && !forced && (m_fmt == 2'd0);
    hold   = m_pix;
    if (ld) m_pix = exp_word(m_fmt, eff, forced, y, c, r, g, b);
    if (v) begin m_phase = eff + 2'd1; m_prevf = forced; end
    @(posedge clk); #2;
    if (!v)        dtag = "R8";
    else if (skip) dtag = "R11";
    else           dtag = pix_tag(m_fmt, forced);
    if (first8) check("R2", {24'd0, pix_o[15:8]}, {24'd0, c});
    check(dtag, {16'd0, pix_o}, {16'd0, (ld ? m_pix : hold)});
    if (!v)              check("R12", {31'd0, dvalid_o}, {31'd0, m_pol});
    else if (m_strobe)   check("R10", {31'd0, dvalid_o}, {31'd0, raw ^ m_pol});
    else if (m_half)     check("R11", {31'd0, dvalid_o}, {31'd0, raw ^ m_pol});
    else if (m_pol)      check("R12", {31'd0, dvalid_o}, {31'd0, raw ^ m_pol});
    else                 check("R9",  {31'd0, dvalid_o}, {31'd0, raw});
    check("R7", {27'd0, blank_o, hsync_o, vsync_o, field_o, vbi_vld_o},
                {27'd0, bl, hs, vs, fd, vb});
  endtask

  task automatic run_line(input logic fd);
    for (int i = 0; i < 4; i++) slot(1'b1, 1'b1, 1'b0, (i < 2), 1'b0, fd);
    for (int i = 0; i < 3; i++) slot(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, fd);
    for (int i = 0; i < 3; i++) slot(1'b1, 1'b1, 1'b0, 1'b0, (i == 0), fd);
    slot(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, fd);
    for (int i = 0; i < 11; i++) slot(($urandom % 5) != 0, 1'b0, 1'b0, 1'b0, 1'b0, fd);
    slot(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, fd);
  endtask

  initial begin : watchdog
    #(200000 * 10);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] cfgs [10];
    void'($urandom(32'd20240611));
    cfgs = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h10, 8'h40, 8'h21, 8'h23, 8'h20, 8'h52};
    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_wr_data = '0;
    in_vld = 0; in_blank = 0; in_hsync = 0; in_vsync = 0; in_field = 0; in_vbi_vld = 0;
    in_y = 0; in_c = 0; in_r = 0; in_g = 0; in_b = 0;
    m_fmt = 0; m_strobe = 0; m_half = 0; m_pol = 0; m_phase = 0; m_prevf = 1; m_pix = 0;
    repeat (4) @(posedge clk);
    #2;
    // R13: reset state
    check("R13", {9'd0, pix_o, dvalid_o, blank_o, hsync_o, vsync_o, field_o, vbi_vld_o}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    check("R13", {15'd0, pix_o, dvalid_o}, 32'd0);
    // first valid slot after reset starts on Cb without a preceding blank
    slot(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    slot(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    foreach (cfgs[k]) begin
      write_cfg(cfgs[k]);
      run_line(1'b0);
      run_line(1'b1);
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule